// File: doc/BRIEF.md
# Off-Hook Startup Timing Sequencer

When a telephone line interface is told to go off-hook, several timed steps must pass before the transmit and receive path may be used. This block times those steps. A request arrives from either a hardware pin or a register bit. The block then runs the following phases in a fixed order:

- a fixed command-latency phase, which covers passing the command across to the line side;
- a settle phase whose length is chosen by a 2-bit select;
- a resistor calibration window, which can be skipped;
- a converter offset calibration window, which can also be skipped.

One tick after the last phase that runs, the block raises a ready level.

Every duration is counted in ticks of an external 1 µs timebase. The parameters `TICKS_PER_MS` and `LAT_TICKS` set how many ticks a millisecond and the latency take. At the default values, a millisecond is 1000 ticks and the latency is 250 ticks. The analog calibration circuits only see the two start strobes and the two busy levels. If the request drops at any point, the sequence aborts at once.

Top module: `ohs_sequencer`

## Requirements
- R1: The sequence starts from idle when `hook_pin` or `hook_reg` is high. In the cycle after the request is seen, `seq_phase` reads 1 (latency). In idle, `seq_phase` reads 0.
- R2: The latency phase lasts exactly `LAT_TICKS` ticks (250 µs by default). After that, `seq_phase` reads 2 (settle).
- R3: The settle phase lasts a number of ticks equal to the selected milliseconds times `TICKS_PER_MS`. The `settle_sel` encoding is 00 = 128 ms, 01 = 8 ms, 10 = 64 ms and 11 = 512 ms. The all-zero reset value of the field therefore gives 128 ms.
- R4: After settle, the resistor calibration phase (`seq_phase` = 3) lasts 17 ms. It is skipped entirely when `rcal_off` is high.
- R5: Next, the converter calibration phase (`seq_phase` = 4) lasts 256 ms. It is skipped entirely when `acal_off` is high.
- R6: Once the last phase that runs has ended, `seq_phase` reads 5 for exactly one tick. It then reads 6, and `path_ready` rises. `path_ready` is high only while `seq_phase` is 6, and it stays high while the request holds.
- R7: If the request drops in any non-idle phase, the next cycle returns the block to idle. In that cycle, `path_ready`, both busy levels and both strobes are low.
- R8: Each calibration phase that runs produces:
  - a one-cycle start strobe in its first cycle;
  - a busy level for every cycle of the phase.
- R9: After reset, `seq_phase` is 0 and every other output is low. Time advances only on cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase tick, one cycle per microsecond |
| hook_pin | input | 1 | Off-hook request from the hardware pin |
| hook_reg | input | 1 | Off-hook request from the register bit |
| settle_sel | input | 2 | Settle duration select |
| rcal_off | input | 1 | Skip the resistor calibration phase |
| acal_off | input | 1 | Skip the converter calibration phase |
| seq_phase | output | 3 | Current phase code (0 to 6) |
| rcal_go | output | 1 | Resistor calibration start strobe |
| rcal_busy | output | 1 | Resistor calibration window |
| acal_go | output | 1 | Converter calibration start strobe |
| acal_busy | output | 1 | Converter calibration window |
| path_ready | output | 1 | Transmit/receive path enabled |

## Verification
The bench builds the block with `TICKS_PER_MS` = 2 and `LAT_TICKS` = 3. Even the 512 ms settle choice then takes only about a thousand ticks, so every settle encoding and every skip combination can run to completion. Every phase boundary is compared against exact tick counts in these runs. The bench uses both one tick per cycle and one tick every other cycle, which shows that only ticks advance time. Aborts are forced in the middle of the settle and calibration phases.

// File: rtl/ohs_pkg.sv
package ohs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LATENCY = 3'd1,
    PH_SETTLE  = 3'd2,
    PH_RCAL    = 3'd3,
    PH_ACAL    = 3'd4,
    PH_TRAIL   = 3'd5,
    PH_READY   = 3'd6
  } phase_e;
endpackage

// File: rtl/ohs_span.sv
// Duration (in ticks) of the phase about to be timed.
module ohs_span
  import ohs_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int LAT_TICKS    = 250,
  parameter int SET0_MS      = 128,
  parameter int SET1_MS      = 8,
  parameter int SET2_MS      = 64,
  parameter int SET3_MS      = 512,
  parameter int RCAL_MS      = 17,
  parameter int ACAL_MS      = 256,
  parameter int CW           = 20
) (
  input  phase_e          ph,
  input  logic [1:0]      settle_sel,
  output logic [CW-1:0]   span
);
  localparam logic [CW-1:0] T_LAT  = CW'(LAT_TICKS);
  localparam logic [CW-1:0] T_S0   = CW'(SET0_MS * TICKS_PER_MS);
  localparam logic [CW-1:0] T_S1   = CW'(SET1_MS * TICKS_PER_MS);
  localparam logic [CW-1:0] T_S2   = CW'(SET2_MS * TICKS_PER_MS);
  localparam logic [CW-1:0] T_S3   = CW'(SET3_MS * TICKS_PER_MS);
  localparam logic [CW-1:0] T_RCAL = CW'(RCAL_MS * TICKS_PER_MS);
  localparam logic [CW-1:0] T_ACAL = CW'(ACAL_MS * TICKS_PER_MS);
  localparam logic [CW-1:0] T_ONE  = CW'(1);

  always_comb begin
    case (ph)
      PH_LATENCY: span = T_LAT;
      PH_SETTLE: begin
        case (settle_sel)
          2'b00:   span = T_S0;
          2'b01:   span = T_S1;
          2'b10:   span = T_S2;
          default: span = T_S3;
        endcase
      end
      PH_RCAL: span = T_RCAL;
      PH_ACAL: span = T_ACAL;
      default: span = T_ONE;
    endcase
  end
endmodule

// File: rtl/ohs_timer.sv
// Tick counter for one phase; expire marks the tick that ends it.
module ohs_timer #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] span,
  output logic          expire
);
  logic [CW-1:0] cnt;

  assign expire = tick && (cnt == span - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= cnt + CW'(1);
  end

  // R9: without a tick or a restart, the count does not move
  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/ohs_sequencer.sv
module ohs_sequencer
  import ohs_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int LAT_TICKS    = 250,
  parameter int SET0_MS      = 128,
  parameter int SET1_MS      = 8,
  parameter int SET2_MS      = 64,
  parameter int SET3_MS      = 512,
  parameter int RCAL_MS      = 17,
  parameter int ACAL_MS      = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       hook_pin,
  input  logic       hook_reg,
  input  logic [1:0] settle_sel,
  input  logic       rcal_off,
  input  logic       acal_off,
  output logic [2:0] seq_phase,
  output logic       rcal_go,
  output logic       rcal_busy,
  output logic       acal_go,
  output logic       acal_busy,
  output logic       path_ready
);
  localparam int MAX_MS01 = (SET0_MS > SET1_MS) ? SET0_MS : SET1_MS;
  localparam int MAX_MS23 = (SET2_MS > SET3_MS) ? SET2_MS : SET3_MS;
  localparam int MAX_MSS  = (MAX_MS01 > MAX_MS23) ? MAX_MS01 : MAX_MS23;
  localparam int MAX_MSC  = (RCAL_MS > ACAL_MS) ? RCAL_MS : ACAL_MS;
  localparam int MAX_MS   = (MAX_MSS > MAX_MSC) ? MAX_MSS : MAX_MSC;
  localparam int MAX_T0   = MAX_MS * TICKS_PER_MS;
  localparam int MAX_T    = (MAX_T0 > LAT_TICKS) ? MAX_T0 : LAT_TICKS;
  localparam int CW       = $clog2(MAX_T + 1);

  phase_e        st_q, st_d;
  logic          req, expire, restart;
  logic [CW-1:0] span;

  assign req = hook_pin | hook_reg;

  ohs_span #(
    .TICKS_PER_MS(TICKS_PER_MS), .LAT_TICKS(LAT_TICKS),
    .SET0_MS(SET0_MS), .SET1_MS(SET1_MS), .SET2_MS(SET2_MS), .SET3_MS(SET3_MS),
    .RCAL_MS(RCAL_MS), .ACAL_MS(ACAL_MS), .CW(CW)
  ) u_span (
    .ph(st_q), .settle_sel(settle_sel), .span(span)
  );

  ohs_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick),
    .span(span), .expire(expire)
  );

  assign restart = (st_d != st_q);

  always_comb begin
    st_d = st_q;
    if (st_q != PH_IDLE && !req) begin
      st_d = PH_IDLE;
    end else begin
      case (st_q)
        PH_IDLE:    if (req) st_d = PH_LATENCY;
        PH_LATENCY: if (expire) st_d = PH_SETTLE;
        PH_SETTLE:  if (expire) st_d = !rcal_off ? PH_RCAL :
                                       !acal_off ? PH_ACAL : PH_TRAIL;
        PH_RCAL:    if (expire) st_d = !acal_off ? PH_ACAL : PH_TRAIL;
        PH_ACAL:    if (expire) st_d = PH_TRAIL;
        PH_TRAIL:   if (expire) st_d = PH_READY;
        default:    st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= PH_IDLE;
      rcal_go    <= 1'b0;
      rcal_busy  <= 1'b0;
      acal_go    <= 1'b0;
      acal_busy  <= 1'b0;
      path_ready <= 1'b0;
    end else begin
      st_q       <= st_d;
      rcal_go    <= (st_d == PH_RCAL) && (st_q != PH_RCAL);
      rcal_busy  <= (st_d == PH_RCAL);
      acal_go    <= (st_d == PH_ACAL) && (st_q != PH_ACAL);
      acal_busy  <= (st_d == PH_ACAL);
      path_ready <= (st_d == PH_READY);
    end
  end

  assign seq_phase = st_q;

  // R8: strobes land inside their busy window and last one cycle
  a_r8_rgo_in_busy: assert property (@(posedge clk) disable iff (rst)
    rcal_go |-> rcal_busy);
  a_r8_ago_in_busy: assert property (@(posedge clk) disable iff (rst)
    acal_go |-> acal_busy);
  a_r8_rgo_single: assert property (@(posedge clk) disable iff (rst)
    rcal_go |=> !rcal_go);
  a_r8_ago_single: assert property (@(posedge clk) disable iff (rst)
    acal_go |=> !acal_go);
  // R7: dropping the request returns to idle with everything low
  a_r7_abort: assert property (@(posedge clk) disable iff (rst)
    !req |=> (seq_phase == 3'd0 && !path_ready && !rcal_busy && !acal_busy));
  // R6: ready is entered only from the trailing tick phase
  a_r6_ready_after_trail: assert property (@(posedge clk) disable iff (rst)
    $rose(path_ready) |-> $past(seq_phase) == 3'd5);
  // R4/R5: at most one calibration window is open
  a_r5_one_window: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rcal_busy, acal_busy, path_ready}));
  // R2: settle is reached only through latency
  a_r2_order: assert property (@(posedge clk) disable iff (rst)
    (seq_phase == 3'd2 && $past(seq_phase) != 3'd2) |-> $past(seq_phase) == 3'd1);
endmodule

// File: tb/tb_ohs_sequencer.sv
module tb_ohs_sequencer;
  localparam int TPM = 2;
  localparam int LAT = 3;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic hook_pin = 1'b0, hook_reg = 1'b0;
  logic [1:0] settle_sel = 2'b00;
  logic rcal_off = 1'b0, acal_off = 1'b0;
  logic [2:0] seq_phase;
  logic rcal_go, rcal_busy, acal_go, acal_busy, path_ready;

  ohs_sequencer #(.TICKS_PER_MS(TPM), .LAT_TICKS(LAT)) dut (
    .clk(clk), .rst(rst), .tick(tick), .hook_pin(hook_pin), .hook_reg(hook_reg),
    .settle_sel(settle_sel), .rcal_off(rcal_off), .acal_off(acal_off),
    .seq_phase(seq_phase), .rcal_go(rcal_go), .rcal_busy(rcal_busy),
    .acal_go(acal_go), .acal_busy(acal_busy), .path_ready(path_ready)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    int    ph;
    int    at;
    string req;
  } item_t;
  item_t exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // tick generator: one tick every tick_every cycles, changed after posedge
  int tick_every = 2;
  int tdiv = 0;
  always @(posedge clk) begin
    #1;
    tdiv = (tdiv + 1) % tick_every;
    tick = (tdiv == 0);
  end

  // monitor: tracks ticks since entry to latency, pops expected transitions
  int tcount = 0;
  bit last_tick = 1'b0;
  int prev_ph = 0;
  always @(negedge clk) begin
    if (rst) begin
      tcount = 0; last_tick = 1'b0; prev_ph = 0;
    end else begin
      tcount += int'(last_tick);
      last_tick = tick;
      if (rcal_go || (rcal_busy && prev_ph != 3))
        chk(rcal_go == (seq_phase == 3 && prev_ph != 3) && rcal_busy, "R8", rcal_go, 1);
      if (acal_go || (acal_busy && prev_ph != 4))
        chk(acal_go == (seq_phase == 4 && prev_ph != 4) && acal_busy, "R8", acal_go, 1);
      if (int'(seq_phase) != prev_ph) begin
        if (seq_phase == 3'd1) tcount = 0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", int'(seq_phase), -1);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(int'(seq_phase) == it.ph, it.req, int'(seq_phase), it.ph);
          if (it.at >= 0) chk(tcount == it.at, it.req, tcount, it.at);
        end
        chk(path_ready == (seq_phase == 3'd6), "R6", path_ready, int'(seq_phase == 3'd6));
        prev_ph = int'(seq_phase);
      end
    end
  end

  function automatic int settle_ms(input logic [1:0] s);
    case (s)
      2'b00: return 128;
      2'b01: return 8;
      2'b10: return 64;
      default: return 512;
    endcase
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_phase(input int ph);
    int n = 0;
    while (int'(seq_phase) != ph && n < 20000) begin
      @(posedge clk); #2; n++;
    end
  endtask

  task automatic push(input int ph, input int at, input string req);
    item_t it;
    it.ph = ph; it.at = at; it.req = req;
    exp_q.push_back(it);
  endtask

  // driver: full sequence to ready, then release
  task automatic run(input logic [1:0] sel, input bit rd, input bit ad,
                     input bit by_pin, input int every);
    int t;
    settle_sel = sel; rcal_off = rd; acal_off = ad; tick_every = every;
    cycles(2);
    push(1, 0, "R1");
    t = LAT;
    push(2, t, "R2");
    t += settle_ms(sel) * TPM;
    if (!rd) begin push(3, t, "R3"); t += 17 * TPM; end
    if (!ad) begin push(4, t, rd ? "R3" : "R4"); t += 256 * TPM; end
    push(5, t, ad ? (rd ? "R3" : "R4") : "R5");
    push(6, t + 1, "R6");
    push(0, -1, "R7");
    if (by_pin) hook_pin = 1'b1; else hook_reg = 1'b1;
    wait_phase(6);
    cycles(7);
    chk(path_ready == 1'b1, "R6", path_ready, 1);
    hook_pin = 1'b0; hook_reg = 1'b0;
    cycles(2);
    chk(seq_phase == 3'd0 && !path_ready, "R7", int'(seq_phase), 0);
    chk(exp_q.size() == 0, "R1", exp_q.size(), 0);
  endtask

  // driver: abort once a given phase has been reached
  task automatic abort_in(input int ph);
    int t;
    settle_sel = 2'b01; rcal_off = 1'b0; acal_off = 1'b0; tick_every = 2;
    cycles(2);
    push(1, 0, "R1");
    t = LAT;
    if (ph >= 2) push(2, t, "R2");
    t += 8 * TPM;
    if (ph >= 3) push(3, t, "R3");
    t += 17 * TPM;
    if (ph >= 4) push(4, t, "R4");
    push(0, -1, "R7");
    hook_reg = 1'b1;
    wait_phase(ph);
    cycles(5);
    hook_reg = 1'b0;
    cycles(1);
    chk(seq_phase == 3'd0, "R7", int'(seq_phase), 0);
    chk(!path_ready && !rcal_busy && !acal_busy && !rcal_go && !acal_go, "R7",
        int'({path_ready, rcal_busy, acal_busy, rcal_go, acal_go}), 0);
    cycles(3);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
  endtask

  initial begin
    rst = 1'b1;
    cycles(4);
    rst = 1'b0;
    cycles(1);
    chk(seq_phase == 3'd0, "R9", int'(seq_phase), 0);
    chk(!path_ready && !rcal_busy && !acal_busy && !rcal_go && !acal_go, "R9",
        int'({path_ready, rcal_busy, acal_busy, rcal_go, acal_go}), 0);
    run(2'b01, 1'b0, 1'b0, 1'b1, 2);  // R1 pin, 8 ms, both calibrations
    run(2'b10, 1'b1, 1'b0, 1'b0, 2);  // R4 skipped, 64 ms
    run(2'b00, 1'b0, 1'b1, 1'b1, 2);  // R5 skipped, default 128 ms
    run(2'b11, 1'b1, 1'b1, 1'b0, 2);  // R3 512 ms, both skipped
    run(2'b01, 1'b1, 1'b1, 1'b1, 1);  // R9 tick every cycle
    run(2'b00, 1'b0, 1'b0, 1'b0, 3);  // R9 sparser ticks
    abort_in(2);
    abort_in(3);
    abort_in(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule